// File: doc/BRIEF.md
# Hotplug Slot Register Controller

This block keeps the hotplug bookkeeping for a bank of up to 32 expansion slots and exposes it to software through a small word-addressed register window. It holds three slot masks: which slots are occupied, which slots have a removal request waiting, and which slots may be removed at all. Software reads these masks and answers a removal request by writing an eject command. The block then pulses a per-slot free strobe that tells the surrounding logic to tear the device down.

Insert and remove events come from the slot side as single-cycle strobes that carry a slot number. A hot insert or a hot remove sets the hotplug bit of a general-purpose event status vector for one cycle, which the surrounding logic turns into an interrupt. An insert flagged as coldplug, which happens while the machine is being built, updates the occupancy mask without any event.

A small state machine controls the work. `ST_IDLE` serves eject commands. A platform reset request moves it `ST_IDLE -> ST_DRAIN`. `ST_DRAIN` executes every waiting removal, lowest slot first, one per cycle, and stays in `ST_DRAIN` while any removal is waiting. With none left it moves `ST_DRAIN -> ST_REBUILD`. `ST_REBUILD` reloads the removable mask from the non-removable inputs and then returns `ST_REBUILD -> ST_IDLE`. The hardware reset puts the machine in `ST_DRAIN`, so the same path runs after power-up.

Top module: `hp_slot_ctrl`

## Requirements
- R1: The window holds four 32-bit words: occupancy-and-removable at offset 0x0, waiting-removal at 0x4, eject/features at 0xC-less-4 (0x8) and removable at 0xC. A read strobed in one cycle presents its data from the next clock edge. Reads of 0x8, of any unmapped offset and of any offset whose low two bits are not zero return zero.
- R2: A read of offset 0x0 returns the occupancy mask ANDed with the removable mask.
- R3: A read of offset 0x4 returns the waiting-removal mask, and a read of offset 0xC returns the removable mask.
- R4: A write to offset 0x8 in `ST_IDLE` selects the lowest set bit of the written data as the slot and clears that slot's waiting-removal bit.
- R5: For a removable slot, an eject clears its occupancy bit and raises that slot's bit of `free_vec` for exactly one cycle. For a slot flagged non-removable, the occupancy bit stays set and `free_vec` stays zero. At most one bit of `free_vec` is ever set.
- R6: A hot insert (`ins_stb` with `evt_cold` low) sets the slot's occupancy bit. A hot remove (`rem_stb`) sets the slot's waiting-removal bit. Each raises bit 1 of `gpe_set` for one cycle, starting at the following clock edge.
- R7: An insert with `evt_cold` high sets the occupancy bit and leaves `gpe_set` at zero.
- R8: A one-cycle `plat_rst` in `ST_IDLE` starts a drain. It frees the waiting slots lowest first, one per cycle from the second edge on. It then loads the removable mask with the inverse of `nonrem` and returns to `ST_IDLE`. Eject writes are ignored until then. After hardware reset all masks read zero except the removable mask, which reads as the inverse of `nonrem`.
- R9: Writes to 0x0, 0x4, 0xC and to misaligned offsets change nothing. An eject write whose data is zero frees no slot and leaves the masks unchanged.
- R10: An insert or remove event in the same cycle as an eject write is applied after the eject. A remove for the ejected slot leaves its waiting bit set, and an insert for it leaves its occupancy bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| plat_rst | input | 1 | Platform reset request, one cycle, starts the drain |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| ins_stb | input | 1 | Slot insert event |
| rem_stb | input | 1 | Slot remove request event |
| evt_slot | input | SLOT_W | Slot number of the event |
| evt_cold | input | 1 | Insert happens at machine build, no event raised |
| nonrem | input | NUM_SLOTS | Per-slot non-removable flags |
| free_vec | output | NUM_SLOTS | One-cycle per-slot device free strobe |
| gpe_set | output | GPE_W | Event status set pulse, hotplug on bit 1 |

## Verification
The bench builds the block with the full 32 slots and a 6-bit offset, so the upper-address decode is present and an offset past the four words (0x10) can be read back as unmapped. With slots 0 and 1 flagged non-removable at reset, it can observe a non-removable eject at the ports. To do this it later clears the flags and runs a platform reset, and the rebuilt removable mask then exposes the occupancy bit that was kept. The full slot width also puts drains across distant bit positions (3, 7, 9, 12, 20) within reach, together with same-cycle eject and event collisions.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_REBUILD = 2'd2
    } hp_state_e;

    // Word index inside the window (byte offset bits [3:2]).
    localparam logic [1:0] WORD_UP    = 2'd0;
    localparam logic [1:0] WORD_DOWN  = 2'd1;
    localparam logic [1:0] WORD_EJECT = 2'd2;
    localparam logic [1:0] WORD_RMV   = 2'd3;

endpackage

// File: rtl/hp_lowbit.sv
// Lowest-set-bit encoder for slot masks.
module hp_lowbit #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |vec_i;

    // The selected index always points at a set bit (R4).
    always_comb begin
        if (any_o === 1'b1) begin
            assert_idx_hit_R4: assert (vec_i[idx_o] == 1'b1);
        end
    end

endmodule

// File: rtl/hp_slot_state.sv
// Slot masks: occupancy, waiting removal, removable; free and event pulses.
module hp_slot_state #(
    parameter int N      = 32,
    parameter int IW     = 5,
    parameter int GPE_W  = 8,
    parameter int HP_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [IW-1:0]    op_idx,
    input  logic             rebuild,
    input  logic [N-1:0]     nonrem,
    input  logic             ins_stb,
    input  logic             rem_stb,
    input  logic [IW-1:0]    evt_slot,
    input  logic             evt_cold,
    output logic [N-1:0]     present_o,
    output logic [N-1:0]     pend_o,
    output logic [N-1:0]     hpen_o,
    output logic [N-1:0]     free_o,
    output logic [GPE_W-1:0] gpe_o
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0]     present_q, pend_q, hpen_q, free_q;
    logic [N-1:0]     present_d, pend_d, hpen_d, free_d;
    logic [GPE_W-1:0] gpe_q, gpe_d;
    logic [N-1:0]     op_hot;
    logic [N-1:0]     evt_hot;

    // One-hot decode of the eject target, one comparator per slot.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            assign op_hot[g] = op_valid && (op_idx == IW'(g));
        end
    endgenerate

    assign evt_hot = ONE << evt_slot;

    always_comb begin
        // Eject first.
        pend_d    = pend_q & ~op_hot;
        free_d    = op_hot & ~nonrem;
        present_d = present_q & ~free_d;
        hpen_d    = hpen_q;
        gpe_d     = '0;
        if (rebuild) hpen_d = ~nonrem;
        // Slot events are applied after the access.
        if (ins_stb) begin
            present_d = present_d | evt_hot;
            if (!evt_cold) gpe_d[HP_BIT] = 1'b1;
        end
        if (rem_stb) begin
            pend_d        = pend_d | evt_hot;
            gpe_d[HP_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_q <= '0;
            pend_q    <= '0;
            hpen_q    <= '1;
            free_q    <= '0;
            gpe_q     <= '0;
        end else begin
            present_q <= present_d;
            pend_q    <= pend_d;
            hpen_q    <= hpen_d;
            free_q    <= free_d;
            gpe_q     <= gpe_d;
        end
    end

    assign present_o = present_q;
    assign pend_o    = pend_q;
    assign hpen_o    = hpen_q;
    assign free_o    = free_q;
    assign gpe_o     = gpe_q;

    assert_free_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(free_q));

    assert_free_removable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((free_q & $past(nonrem)) == '0));

    assert_cold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_stb && evt_cold && !rem_stb) |=> !gpe_q[HP_BIT]);

    // Remove wins over a same-cycle eject of the same slot (R6, R10).
    assert_remove_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rem_stb |=> (gpe_q[HP_BIT] && ((pend_q & (ONE << $past(evt_slot))) != '0)));

    assert_insert_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_stb |=> ((present_q & (ONE << $past(evt_slot))) != '0));

endmodule

// File: rtl/hp_reg_read.sv
// Registered read decode of the four-word window.
module hp_reg_read #(
    parameter int N  = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [N-1:0]  present,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  hpen,
    output logic [31:0]   rd_data
);
    import hp_pkg::*;

    logic        hi_zero;
    logic        aligned;
    logic [1:0]  word;
    logic [31:0] rd_d;

    // Offsets above the window only exist when the address is wider than 4 bits.
    generate
        if (AW > 4) begin : g_hi
            assign hi_zero = (rd_addr[AW-1:4] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign aligned = (rd_addr[1:0] == 2'b00);
    assign word    = rd_addr[3:2];

    always_comb begin
        rd_d = '0;
        if (hi_zero && aligned) begin
            unique case (word)
                WORD_UP:    rd_d = 32'(present & hpen);
                WORD_DOWN:  rd_d = 32'(pend);
                WORD_EJECT: rd_d = '0;
                WORD_RMV:   rd_d = 32'(hpen);
                default:    rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_d;
    end

    assert_up_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == AW'(0)) |=> ((rd_data & ~32'($past(hpen))) == '0));

    assert_feature_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == AW'(8)) |=> (rd_data == '0));

endmodule

// File: rtl/hp_slot_ctrl.sv
// Hotplug slot register controller: top with drain/rebuild state machine.
module hp_slot_ctrl #(
    parameter int NUM_SLOTS  = 32,
    parameter int ADDR_W     = 4,
    parameter int GPE_W      = 8,
    parameter int HP_GPE_BIT = 1,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 plat_rst,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    input  logic                 ins_stb,
    input  logic                 rem_stb,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic                 evt_cold,
    input  logic [NUM_SLOTS-1:0] nonrem,
    output logic [NUM_SLOTS-1:0] free_vec,
    output logic [GPE_W-1:0]     gpe_set
);
    import hp_pkg::*;

    hp_state_e             state_q, state_d;
    logic                  ej_hit;
    logic [SLOT_W-1:0]     ej_idx, dr_idx, op_idx;
    logic                  ej_any, dr_any, op_valid, rebuild;
    logic [NUM_SLOTS-1:0]  present, pend, hpen;

    assign ej_hit = wr_en && (addr == ADDR_W'(8));

    hp_lowbit #(.N(NUM_SLOTS), .IW(SLOT_W)) u_ej_enc (
        .vec_i (wr_data[NUM_SLOTS-1:0]),
        .idx_o (ej_idx),
        .any_o (ej_any)
    );

    hp_lowbit #(.N(NUM_SLOTS), .IW(SLOT_W)) u_dr_enc (
        .vec_i (pend),
        .idx_o (dr_idx),
        .any_o (dr_any)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DRAIN;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (plat_rst) state_d = ST_DRAIN;
            ST_DRAIN:   if (!dr_any)  state_d = ST_REBUILD;
            ST_REBUILD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State outputs.
    always_comb begin
        op_valid = 1'b0;
        op_idx   = ej_idx;
        rebuild  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                op_valid = ej_hit && ej_any;
                op_idx   = ej_idx;
            end
            ST_DRAIN: begin
                op_valid = dr_any;
                op_idx   = dr_idx;
            end
            ST_REBUILD: rebuild = 1'b1;
            default: ;
        endcase
    end

    hp_slot_state #(
        .N(NUM_SLOTS), .IW(SLOT_W), .GPE_W(GPE_W), .HP_BIT(HP_GPE_BIT)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_idx    (op_idx),
        .rebuild   (rebuild),
        .nonrem    (nonrem),
        .ins_stb   (ins_stb),
        .rem_stb   (rem_stb),
        .evt_slot  (evt_slot),
        .evt_cold  (evt_cold),
        .present_o (present),
        .pend_o    (pend),
        .hpen_o    (hpen),
        .free_o    (free_vec),
        .gpe_o     (gpe_set)
    );

    hp_reg_read #(.N(NUM_SLOTS), .AW(ADDR_W)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (addr),
        .present (present),
        .pend    (pend),
        .hpen    (hpen),
        .rd_data (rd_data)
    );

    assert_drain_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !dr_any) |=> (state_q == ST_REBUILD));

    assert_rebuild_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REBUILD) |=> (hpen == ~$past(nonrem)));

    assert_free_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vec != '0) |-> $past(op_valid));

    assert_busy_no_eject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !dr_any) |=> (free_vec == '0));

endmodule

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb;

    localparam int NS = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n, plat_rst, rd_en, wr_en, ins_stb, rem_stb, evt_cold;
    logic [AW-1:0] addr;
    logic [31:0]   wr_data, rd_data;
    logic [4:0]    evt_slot;
    logic [NS-1:0] nonrem, free_vec;
    logic [7:0]    gpe_set;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hp_slot_ctrl #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .ins_stb(ins_stb), .rem_stb(rem_stb), .evt_slot(evt_slot),
        .evt_cold(evt_cold), .nonrem(nonrem), .free_vec(free_vec),
        .gpe_set(gpe_set)
    );

    typedef struct packed {
        logic        is_rd;
        logic [5:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // State entering the table: occupied 0,5,9,12; removable FFFFFFFC; none waiting.
    localparam vec_t TBL [11] = '{
        '{1'b1, 6'h00, 32'h0,        32'h0000_1220, 8'd2},  // R2 up = present & removable
        '{1'b1, 6'h08, 32'h0,        32'h0000_0000, 8'd1},  // R1 features read zero
        '{1'b1, 6'h10, 32'h0,        32'h0000_0000, 8'd1},  // R1 unmapped offset
        '{1'b1, 6'h02, 32'h0,        32'h0000_0000, 8'd1},  // R1 misaligned read
        '{1'b0, 6'h00, 32'hFFFF_FFFF, 32'h0,        8'd9},  // R9 write up ignored
        '{1'b1, 6'h00, 32'h0,        32'h0000_1220, 8'd9},
        '{1'b0, 6'h0C, 32'h0,        32'h0,         8'd9},  // R9 write removable ignored
        '{1'b1, 6'h0C, 32'h0,        32'hFFFF_FFFC, 8'd3},  // R3 removable word
        '{1'b0, 6'h04, 32'hFFFF_FFFF, 32'h0,        8'd9},  // R9 write down ignored
        '{1'b1, 6'h04, 32'h0,        32'h0000_0000, 8'd3},  // R3 down word
        '{1'b0, 6'h0A, 32'h0000_1000, 32'h0,        8'd9}   // R9 misaligned eject ignored
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_rd(input logic [AW-1:0] a, output logic [31:0] q);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic slot_evt(input logic ins, input logic rem, input logic [4:0] s, input logic cold);
        ins_stb = ins; rem_stb = rem; evt_slot = s; evt_cold = cold;
        tick();
        ins_stb = 1'b0; rem_stb = 1'b0; evt_cold = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        rst_n = 1'b0; plat_rst = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        addr = '0; wr_data = '0; ins_stb = 1'b0; rem_stb = 1'b0;
        evt_slot = '0; evt_cold = 1'b0; nonrem = 32'h0000_0003;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) tick();

        // R8 hardware reset state
        check("R8 reset free", free_vec, '0);
        check("R8 reset gpe", 32'(gpe_set), '0);
        do_rd(6'h00, q); check("R8 reset up", q, '0);
        do_rd(6'h04, q); check("R8 reset down", q, '0);
        do_rd(6'h0C, q); check("R8 reset removable", q, 32'hFFFF_FFFC);

        // R7 coldplug inserts: no event
        slot_evt(1'b1, 1'b0, 5'd0, 1'b1); check("R7 cold slot0 gpe", 32'(gpe_set), '0);
        slot_evt(1'b1, 1'b0, 5'd5, 1'b1); check("R7 cold slot5 gpe", 32'(gpe_set), '0);
        slot_evt(1'b1, 1'b0, 5'd9, 1'b1); check("R7 cold slot9 gpe", 32'(gpe_set), '0);
        // R6 hot insert
        slot_evt(1'b1, 1'b0, 5'd12, 1'b0); check("R6 insert gpe bit1", 32'(gpe_set), 32'h2);
        tick(); check("R6 gpe one cycle", 32'(gpe_set), '0);

        // Table walk: R1 R2 R3 R9
        foreach (TBL[i]) begin
            if (TBL[i].is_rd) begin
                do_rd(TBL[i].a, q);
                check($sformatf("R%0d table row %0d", TBL[i].req, i), q, TBL[i].exp);
            end else begin
                do_wr(TBL[i].a, TBL[i].d);
                check($sformatf("R%0d table row %0d free", TBL[i].req, i), free_vec, '0);
            end
        end

        // R6 hot removes
        slot_evt(1'b0, 1'b1, 5'd5, 1'b0); check("R6 remove gpe bit1", 32'(gpe_set), 32'h2);
        slot_evt(1'b0, 1'b1, 5'd12, 1'b0);
        do_rd(6'h04, q); check("R6 down after removes", q, 32'h0000_1020);

        // R4 R5 eject picks lowest pending (slot 5)
        do_wr(6'h08, 32'h0000_1020); check("R5 free slot5", free_vec, 32'h0000_0020);
        tick(); check("R5 free one cycle", free_vec, '0);
        do_rd(6'h04, q); check("R4 down after eject", q, 32'h0000_1000);
        do_rd(6'h00, q); check("R5 up after eject", q, 32'h0000_1200);

        // R9 zero eject
        do_wr(6'h08, 32'h0); check("R9 zero eject free", free_vec, '0);
        do_rd(6'h04, q); check("R9 zero eject down", q, 32'h0000_1000);

        // R5 non-removable eject (slot 0)
        slot_evt(1'b0, 1'b1, 5'd0, 1'b0);
        do_wr(6'h08, 32'h0000_0001); check("R5 nonrem no free", free_vec, '0);
        do_rd(6'h04, q); check("R4 nonrem down cleared", q, 32'h0000_1000);

        // R8 platform reset: drain slot 12, eject during drain ignored, rebuild
        nonrem = '0;
        plat_rst = 1'b1; tick(); plat_rst = 1'b0;
        do_wr(6'h08, 32'h0000_0200); check("R8 drain frees slot12", free_vec, 32'h0000_1000);
        tick(); check("R8 drain done", free_vec, '0);
        tick();
        do_rd(6'h0C, q); check("R8 rebuilt removable", q, 32'hFFFF_FFFF);
        do_rd(6'h00, q); check("R5 R8 slot0 kept, slot9 not ejected", q, 32'h0000_0201);
        do_rd(6'h04, q); check("R8 down empty", q, '0);

        // R10 remove and eject of slot 9 in the same cycle
        rem_stb = 1'b1; evt_slot = 5'd9;
        do_wr(6'h08, 32'h0000_0200); rem_stb = 1'b0;
        check("R10 free slot9", free_vec, 32'h0000_0200);
        check("R10 gpe", 32'(gpe_set), 32'h2);
        do_rd(6'h04, q); check("R10 remove kept", q, 32'h0000_0200);
        do_rd(6'h00, q); check("R10 up after", q, 32'h0000_0001);
        // R10 insert and eject of slot 20 in the same cycle
        ins_stb = 1'b1; evt_slot = 5'd20;
        do_wr(6'h08, 32'h0010_0000); ins_stb = 1'b0;
        check("R10 free slot20", free_vec, 32'h0010_0000);
        do_rd(6'h00, q); check("R10 insert kept", q, 32'h0010_0001);

        // R8 drain order over several slots: 3, 7, 9
        slot_evt(1'b0, 1'b1, 5'd7, 1'b0);
        slot_evt(1'b0, 1'b1, 5'd3, 1'b0);
        plat_rst = 1'b1; tick(); plat_rst = 1'b0;
        tick(); check("R8 order first slot3", free_vec, 32'h0000_0008);
        tick(); check("R8 order second slot7", free_vec, 32'h0000_0080);
        tick(); check("R8 order third slot9", free_vec, 32'h0000_0200);
        tick(); check("R8 order end", free_vec, '0);
        tick();
        do_rd(6'h04, q); check("R8 down drained", q, '0);
        do_rd(6'h00, q); check("R8 up after drain", q, 32'h0010_0001);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule